// File: doc/BRIEF.md
# Configuration Cycle Address Router

This block sits on the host side of the port-based PCI configuration mechanism. It holds a 32-bit address latch in processor I/O space. The latch selects which bus, device, function and dword register a later access to the data window will reach. When a data-window access arrives and the latch is enabled, the block classifies the cycle. The cycle can be claimed by the on-chip devices, sent over the downstream link as a Type 0 or Type 1 configuration cycle, or sent to the graphics port as a Type 0 or Type 1 cycle. The graphics port owns a bus span, and the span is given by the secondary and subordinate bus numbers on two input ports.

An access to the latch address that does not use all four bytes does not touch the latch. Such an access leaves as a plain I/O cycle, and so does any data-window access while the latch is disabled. Every routing result and every latch read appears on registered outputs one clock after the request. Packet building, link transfer and the device register files belong to other blocks.

Top module: `cfgr_top`

## Requirements
- R1: After reset the latch holds 0, and a dword read of the latch port (dword index 0x33E, all four byte enables) returns 0.
- R2: A dword write to the latch port stores bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register). Bits 30:24 and 1:0 always read 0. A dword read raises rd_valid with the latch value one cycle after the request and produces no route.
- R3: An access to the latch port with any byte enable clear leaves the latch unchanged. One cycle later it appears as a route with rt_dest=0 (plain I/O), carrying the access's address, byte enables, direction and data.
- R4: An access to the data window (dword index 0x33F) while latch bit 31 is 0 is routed as plain I/O (rt_dest=0).
- R5: With the enable set, bus 0 and device 0, 1, 2 or 7, the access is routed to the internal devices (rt_dest=1) as Type 0. rt_fill_ones is set exactly when such an access is a read with a non-zero function number.
- R6: With the enable set, bus 0 and any other device number, the access goes to the downstream link (rt_dest=2) as Type 0.
- R7: With a non-zero bus equal to the secondary bus, and the subordinate bus not below the secondary bus, the access goes to the graphics port (rt_dest=3) as Type 0.
- R8: With a bus above the secondary bus and at most the subordinate bus, the access goes to the graphics port as Type 1.
- R9: Any other non-zero bus goes to the downstream link as Type 1. When the subordinate bus is below the secondary bus, this covers the secondary number itself.
- R10: A configuration route shows the latch's bus, device, function and register fields. It also shows the byte enables, direction and write data of the window access, one cycle after the request. Routing uses the bus-span inputs present in the request cycle and a latch written on the cycle before.
- R11: Requests to any other address produce neither a route nor a read response. A route and a read response are never valid together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | I/O request present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 14 | Dword index of the I/O address |
| io_be | input | 4 | Byte enables within the dword |
| io_wdata | input | 32 | Write data |
| sec_bus | input | 8 | First bus behind the graphics port |
| sub_bus | input | 8 | Last bus behind the graphics port |
| rd_valid | output | 1 | Latch read response valid |
| rd_data | output | 32 | Latch read value |
| rt_valid | output | 1 | Route result valid |
| rt_dest | output | 2 | 0 plain I/O, 1 internal, 2 downstream link, 3 graphics port |
| rt_type1 | output | 1 | 1 = Type 1 configuration cycle |
| rt_fill_ones | output | 1 | Read of an absent internal function, return all ones |
| rt_bus | output | 8 | Target bus number |
| rt_dev | output | 5 | Target device number |
| rt_func | output | 3 | Target function number |
| rt_reg | output | 6 | Target dword register number |
| rt_be | output | 4 | Byte enables of the access |
| rt_write | output | 1 | Direction of the access |
| rt_wdata | output | 32 | Write data of the access |
| rt_io_addr | output | 14 | Dword index of the original access |

## Verification
Two things can meet in adjacent cycles or the same cycle. A latch write can be followed at once by a window access that must already see the new fields. The bus-span inputs can change in the very cycle of a window access. The bench drives both back to back with no idle gap between them. It also changes the span on the same clock as the access. The result is judged against a behavioural model that evaluates the latch contents and span values as of that request cycle.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef enum logic [1:0] {
    DST_IO    = 2'd0,
    DST_LOCAL = 2'd1,
    DST_LINK  = 2'd2,
    DST_GFX   = 2'd3
  } dest_e;

  // Device claimed by the on-chip bridge when its bit is set in the mask.
  function automatic logic dev_is_local(input logic [31:0] mask, input logic [4:0] dev);
    return mask[dev];
  endfunction

  // Graphics span is empty when the last bus lies below the first.
  function automatic logic span_valid(input logic [7:0] first, input logic [7:0] last);
    return last >= first;
  endfunction

  // Strictly behind the first bus and not past the last.
  function automatic logic behind_first(input logic [7:0] bus, input logic [7:0] first,
                                        input logic [7:0] last);
    return (bus > first) && (bus <= last);
  endfunction

endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg #(
  parameter logic [31:0] KEEP_MASK = 32'h80FF_FFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] cfg_word,
  output logic        cfg_en,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [5:0]  cfg_reg
);

  logic [31:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (wr_en)  word_q <= wdata & KEEP_MASK;
  end

  assign cfg_word = word_q;
  assign cfg_en   = word_q[31];
  assign cfg_bus  = word_q[23:16];
  assign cfg_dev  = word_q[15:11];
  assign cfg_func = word_q[10:8];
  assign cfg_reg  = word_q[7:2];

endmodule

// File: rtl/cfgr_target_sel.sv
module cfgr_target_sel
  import cfgr_pkg::*;
#(
  parameter logic [31:0] LOCAL_DEV_MASK = 32'h0000_0087
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus,
  input  logic [4:0] dev,
  input  logic [7:0] sec_bus,
  input  logic [7:0] sub_bus,
  output dest_e      dest,
  output logic       type1
);

  logic bus_zero;
  logic span_ok;
  logic hit_sec;
  logic hit_behind;
  logic dev_local;

  assign bus_zero   = (bus == 8'd0);
  assign span_ok    = span_valid(sec_bus, sub_bus);
  assign hit_sec    = span_ok && (bus == sec_bus);
  assign hit_behind = behind_first(bus, sec_bus, sub_bus);
  assign dev_local  = dev_is_local(LOCAL_DEV_MASK, dev);

  always_comb begin
    dest  = DST_LINK;
    type1 = 1'b1;
    if (bus_zero) begin
      type1 = 1'b0;
      dest  = dev_local ? DST_LOCAL : DST_LINK;
    end else if (hit_sec) begin
      dest  = DST_GFX;
      type1 = 1'b0;
    end else if (hit_behind) begin
      dest  = DST_GFX;
      type1 = 1'b1;
    end
  end

  // R5: internal claim only on bus 0 and always Type 0
  p_local_bus0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dest == DST_LOCAL) |-> (bus_zero && !type1));

  // R8: graphics routing requires a non-empty span containing the bus
  p_gfx_in_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dest == DST_GFX) |-> (sub_bus >= sec_bus && bus >= sec_bus && bus <= sub_bus));

  // R9: an empty span never reaches the graphics port
  p_empty_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_bus < sec_bus) |-> (dest != DST_GFX));

endmodule

// File: rtl/cfgr_top.sv
module cfgr_top
  import cfgr_pkg::*;
#(
  parameter int          IO_AW          = 14,
  parameter logic [13:0] ADDR_PORT      = 14'h33E,
  parameter logic [13:0] DATA_PORT      = 14'h33F,
  parameter logic [31:0] LOCAL_DEV_MASK = 32'h0000_0087
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  input  logic [7:0]       sec_bus,
  input  logic [7:0]       sub_bus,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic             rt_valid,
  output logic [1:0]       rt_dest,
  output logic             rt_type1,
  output logic             rt_fill_ones,
  output logic [7:0]       rt_bus,
  output logic [4:0]       rt_dev,
  output logic [2:0]       rt_func,
  output logic [5:0]       rt_reg,
  output logic [3:0]       rt_be,
  output logic             rt_write,
  output logic [31:0]      rt_wdata,
  output logic [IO_AW-1:0] rt_io_addr
);

  localparam logic [3:0] FULL_BE = '1;

  logic [31:0] cfg_word;
  logic        cfg_en;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  dest_e       sel_dest;
  logic        sel_type1;

  // Named request events
  logic hit_latch, hit_window, full_dword;
  logic latch_wr, latch_rd, cfg_cycle, pass_io, route_fire, absent_fn;

  assign hit_latch  = io_valid && (io_addr == ADDR_PORT);
  assign hit_window = io_valid && (io_addr == DATA_PORT);
  assign full_dword = (io_be == FULL_BE);
  assign latch_wr   = hit_latch && full_dword && io_write;
  assign latch_rd   = hit_latch && full_dword && !io_write;
  assign cfg_cycle  = hit_window && cfg_en;
  assign pass_io    = (hit_latch && !full_dword) || (hit_window && !cfg_en);
  assign route_fire = cfg_cycle || pass_io;
  assign absent_fn  = cfg_cycle && (sel_dest == DST_LOCAL) && !io_write && (cfg_func != 3'd0);

  cfgr_addr_reg u_addr_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (latch_wr),
    .wdata    (io_wdata),
    .cfg_word (cfg_word),
    .cfg_en   (cfg_en),
    .cfg_bus  (cfg_bus),
    .cfg_dev  (cfg_dev),
    .cfg_func (cfg_func),
    .cfg_reg  (cfg_reg)
  );

  cfgr_target_sel #(.LOCAL_DEV_MASK(LOCAL_DEV_MASK)) u_target_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus     (cfg_bus),
    .dev     (cfg_dev),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .dest    (sel_dest),
    .type1   (sel_type1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rt_valid     <= 1'b0;
      rt_dest      <= DST_IO;
      rt_type1     <= 1'b0;
      rt_fill_ones <= 1'b0;
      rt_bus       <= '0;
      rt_dev       <= '0;
      rt_func      <= '0;
      rt_reg       <= '0;
      rt_be        <= '0;
      rt_write     <= 1'b0;
      rt_wdata     <= '0;
      rt_io_addr   <= '0;
    end else begin
      rd_valid     <= latch_rd;
      rd_data      <= latch_rd ? cfg_word : '0;
      rt_valid     <= route_fire;
      rt_dest      <= pass_io ? DST_IO : sel_dest;
      rt_type1     <= pass_io ? 1'b0 : sel_type1;
      rt_fill_ones <= absent_fn;
      rt_bus       <= cfg_bus;
      rt_dev       <= cfg_dev;
      rt_func      <= cfg_func;
      rt_reg       <= cfg_reg;
      rt_be        <= io_be;
      rt_write     <= io_write;
      rt_wdata     <= io_wdata;
      rt_io_addr   <= io_addr;
    end
  end

  // R2: a dword latch read answers on the next cycle
  p_read_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_rd |=> rd_valid);

  // R3: a partial access to the latch port leaves the latch alone
  p_partial_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_latch && !full_dword) |=> $stable(cfg_word));

  // R4: configuration destinations only when the latch was enabled
  p_cfg_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_window && !cfg_en) |=> (rt_valid && rt_dest == DST_IO));

  // R11: route and read response never overlap
  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rt_valid, rd_valid}) <= 1);

  // R11: foreign addresses produce nothing
  p_foreign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_latch && !hit_window) |=> (!rt_valid && !rd_valid));

endmodule

// File: tb/cfgr_top_bench.sv
module cfgr_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [13:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [7:0]  sec_bus = '0;
  logic [7:0]  sub_bus = '0;
  logic        rd_valid, rt_valid, rt_type1, rt_fill_ones, rt_write;
  logic [31:0] rd_data, rt_wdata;
  logic [1:0]  rt_dest;
  logic [7:0]  rt_bus;
  logic [4:0]  rt_dev;
  logic [2:0]  rt_func;
  logic [5:0]  rt_reg;
  logic [3:0]  rt_be;
  logic [13:0] rt_io_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_latch = 32'h0;

  always #5 clk = ~clk;

  cfgr_top u_cfgr_top (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
    .sec_bus(sec_bus), .sub_bus(sub_bus),
    .rd_valid(rd_valid), .rd_data(rd_data), .rt_valid(rt_valid),
    .rt_dest(rt_dest), .rt_type1(rt_type1), .rt_fill_ones(rt_fill_ones),
    .rt_bus(rt_bus), .rt_dev(rt_dev), .rt_func(rt_func), .rt_reg(rt_reg),
    .rt_be(rt_be), .rt_write(rt_write), .rt_wdata(rt_wdata), .rt_io_addr(rt_io_addr)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One request cycle: drive at negedge, compare at the following negedge.
  task automatic acc(input logic v, input logic w, input logic [13:0] a,
                     input logic [3:0] be, input logic [31:0] d, input string tag);
    bit e_rd = 0, e_rt = 0, e_t1 = 0, e_fill = 0;
    int e_dest = 0;
    logic [31:0] e_rdata = 0;
    int b = model_latch[23:16];
    int dv = model_latch[15:11];
    int fn = model_latch[10:8];
    int s = sec_bus;
    int u = sub_bus;
    io_valid = v; io_write = w; io_addr = a; io_be = be; io_wdata = d;
    if (v && a == 14'h33E) begin
      if (be == 4'hF) begin
        if (!w) begin e_rd = 1; e_rdata = model_latch; end
      end else begin
        e_rt = 1; e_dest = 0;
      end
    end else if (v && a == 14'h33F) begin
      e_rt = 1;
      if (model_latch[31] == 1'b0) e_dest = 0;
      else if (b == 0) begin
        if (dv == 0 || dv == 1 || dv == 2 || dv == 7) begin
          e_dest = 1; e_fill = (!w && fn != 0);
        end else e_dest = 2;
      end else if (u >= s && b == s) e_dest = 3;
      else if (b > s && b <= u) begin e_dest = 3; e_t1 = 1; end
      else begin e_dest = 2; e_t1 = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    if (v && a == 14'h33E && be == 4'hF && w) model_latch = d & 32'h80FF_FFFC;
    check(tag, "rd_valid", 32'(rd_valid), 32'(e_rd));
    if (e_rd) check(tag, "rd_data", rd_data, e_rdata);
    check(tag, "rt_valid", 32'(rt_valid), 32'(e_rt));
    if (e_rt) begin
      check(tag, "rt_dest", 32'(rt_dest), 32'(e_dest));
      check(tag, "rt_be", 32'(rt_be), 32'(be));
      check(tag, "rt_write", 32'(rt_write), 32'(w));
      if (w) check(tag, "rt_wdata", rt_wdata, d);
      if (e_dest == 0) check(tag, "rt_io_addr", 32'(rt_io_addr), 32'(a));
      else begin
        check(tag, "rt_type1", 32'(rt_type1), 32'(e_t1));
        check(tag, "rt_fill_ones", 32'(rt_fill_ones), 32'(e_fill));
        check(tag, "rt_bus", 32'(rt_bus), 32'(b));
        check(tag, "rt_dev", 32'(rt_dev), 32'(dv));
        check(tag, "rt_func", 32'(rt_func), 32'(fn));
        check(tag, "rt_reg", 32'(rt_reg), 32'(model_latch[7:2]));
      end
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input int b, input int dv,
                                     input int fn, input int rg);
    return {en, 7'h00, 8'(b), 5'(dv), 3'(fn), 6'(rg), 2'b00};
  endfunction

  task automatic cfg_probe(input int b, input int dv, input int fn, input bit w, input string tag);
    acc(1, 1, 14'h33E, 4'hF, mk(1, b, dv, fn, 5), tag);
    acc(1, w, 14'h33F, 4'b0110, 32'h1234_5678, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset rd_valid", 32'(rd_valid), 0);
    check("R1", "reset rt_valid", 32'(rt_valid), 0);
    rst_n = 1'b1;
    acc(0, 0, 0, 0, 0, "R11");
    acc(1, 0, 14'h33E, 4'hF, 0, "R1");                      // reset latch reads 0
    acc(1, 1, 14'h33E, 4'hF, 32'hFFFF_FFFF, "R2");
    acc(1, 0, 14'h33E, 4'hF, 0, "R2");                      // reserved bits read 0
    acc(1, 1, 14'h33E, 4'h1, 32'h0, "R3");                  // byte write passes through
    acc(1, 0, 14'h33E, 4'h3, 32'h0, "R3");                  // word read passes through
    acc(1, 0, 14'h33E, 4'hF, 0, "R3");                      // latch unchanged
    acc(1, 1, 14'h33E, 4'hF, mk(0, 5, 3, 0, 1), "R4");
    acc(1, 0, 14'h33F, 4'hF, 0, "R4");
    acc(1, 1, 14'h33F, 4'h8, 32'hAA00_0000, "R4");
    acc(1, 1, 14'h040, 4'hF, 32'h5, "R11");                 // foreign address
    acc(1, 0, 14'h33D, 4'hF, 0, "R11");
    // bus 0
    cfg_probe(0, 0, 0, 0, "R5");
    cfg_probe(0, 1, 3, 0, "R5");
    cfg_probe(0, 2, 1, 1, "R5");
    cfg_probe(0, 7, 0, 0, "R5");
    cfg_probe(0, 7, 6, 0, "R5");
    cfg_probe(0, 3, 2, 0, "R6");
    cfg_probe(0, 6, 0, 1, "R6");
    cfg_probe(0, 8, 0, 0, "R6");
    cfg_probe(0, 31, 7, 0, "R6");
    // graphics span 4..9
    sec_bus = 8'd4; sub_bus = 8'd9;
    cfg_probe(4, 0, 0, 0, "R7");
    cfg_probe(5, 1, 0, 1, "R8");
    cfg_probe(9, 2, 0, 0, "R8");
    cfg_probe(3, 0, 0, 0, "R9");
    cfg_probe(10, 0, 0, 1, "R9");
    cfg_probe(255, 0, 0, 0, "R9");
    // empty span
    sec_bus = 8'd9; sub_bus = 8'd4;
    cfg_probe(9, 0, 0, 0, "R9");
    cfg_probe(5, 0, 0, 0, "R9");
    // single-bus span
    sec_bus = 8'd6; sub_bus = 8'd6;
    cfg_probe(6, 4, 0, 0, "R7");
    cfg_probe(7, 4, 0, 0, "R9");
    // span changes in the same cycle as the window access
    acc(1, 1, 14'h33E, 4'hF, mk(1, 20, 1, 2, 9), "R10");
    sec_bus = 8'd20; sub_bus = 8'd30;
    acc(1, 0, 14'h33F, 4'h1, 0, "R10");
    sec_bus = 8'd10; sub_bus = 8'd30;
    acc(1, 1, 14'h33F, 4'hC, 32'hDEAD_BEEF, "R10");
    sec_bus = 8'd21; sub_bus = 8'd30;
    acc(1, 0, 14'h33F, 4'hF, 0, "R10");
    // every bus against a mid span, back to back
    sec_bus = 8'd100; sub_bus = 8'd180;
    for (int b = 0; b < 256; b++) begin
      acc(1, 1, 14'h33E, 4'hF, mk(1, b, b % 32, b % 8, b % 64), "R10");
      acc(1, b % 2, 14'h33F, 4'(b % 16), 32'(b * 7), "R10");
    end
    acc(0, 0, 0, 0, 0, "R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule